// File: doc/BRIEF.md
# Cascadable Four-Bit Up/Down Counter

This block is a synchronous four-bit counter clocked on the rising edge. Two mode selects pick one of four operations: parallel load, count up, count down, or stop. An active-low carry input either lets the up or down step happen or holds the count. An active-low carry output drops at the terminal count for the current direction, and it also drops whenever load is selected.

Stages can be chained into a wider counter on one clock. Each stage's carry output goes to the next stage's carry input, and every stage gets the same selects. In either count mode the chain then counts as one wide binary value. The top module holds a parameterised number of stages, and the first stage's carry input is brought out as the enable for the whole chain.

A synchronous active-high reset clears every count to zero. It is there only to give simulation a known start.

Top module: `hexcnt_chain`

## Requirements
- R1: The mode select `mode_sel` is a 2-bit field in which bit 1 is the first select and bit 0 the second. Code 2'b00 is load: on the next rising edge every stage takes its nibble of `load_val` (stage k uses bits 4k+3..4k), whatever the carry input is.
- R2: Code 2'b01 is count up. A stage whose carry input is low adds one on the rising edge and wraps from 15 to 0.
- R3: Code 2'b10 is count down. A stage whose carry input is low subtracts one and wraps from 0 to 15.
- R4: In either count mode, a stage whose carry input is high keeps its value.
- R5: Code 2'b11 is stop. Every stage keeps its value whatever the carry input is.
- R6: A stage's carry output is low when load is selected. It is also low when its carry input is low and either the mode is up with the count at 15, or the mode is down with the count at 0. In every other case it is high, and this includes stop mode. The carry output follows the carry input combinationally.
- R7: With carry outputs chained to carry inputs and `cin_n` low, the concatenated `count` steps by one as a single STAGES*4-bit binary value in up mode and in down mode, wrapping at the ends of the full range. `cout_n` is the carry output of the last stage.
- R8: While `rst` is high, every count is cleared to 0 on the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset, for simulation only |
| mode_sel | input | 2 | Mode: 00 load, 01 up, 10 down, 11 stop |
| cin_n | input | 1 | Active-low carry input to stage 0 (chain enable) |
| load_val | input | STAGES*4 | Parallel load value, stage 0 in the low nibble |
| count | output | STAGES*4 | Registered count, stage 0 in the low nibble |
| cout_n | output | 1 | Active-low carry output of the last stage |

## Verification
A wrong stored count shows up on `count` one edge after the step that produced it. It then shows up again on `cout_n` in the same cycle whenever the terminal value is involved. A stage whose carry decode is wrong does not corrupt its own nibble. It makes the next nibble step at the wrong moment, so a fault in the low stage shows at the high nibble on the following edge. The bench predicts every edge with a wide-integer model and compares both `count` and `cout_n` before each edge. Because of that, a fault appears at most one cycle after its cause.

// File: rtl/hexcnt_pkg.sv
package hexcnt_pkg;
  typedef enum logic [1:0] {
    MODE_LOAD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_STOP = 2'b11
  } mode_e;
endpackage

// File: rtl/hexcnt_ctrl.sv
module hexcnt_ctrl
  import hexcnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [1:0]   mode_sel,
  input  logic         cin_n,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt,
  output logic         cout_n
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  mode_e m;
  assign m = mode_e'(mode_sel);

  always_comb begin
    nxt = cnt;
    unique case (m)
      MODE_LOAD: nxt = din;
      MODE_UP:   if (!cin_n) nxt = cnt + 1'b1;
      MODE_DOWN: if (!cin_n) nxt = cnt - 1'b1;
      default:   nxt = cnt;
    endcase
  end

  always_comb begin
    cout_n = 1'b1;
    if (m == MODE_LOAD) cout_n = 1'b0;
    else if (!cin_n && m == MODE_UP && cnt == TOP) cout_n = 1'b0;
    else if (!cin_n && m == MODE_DOWN && cnt == '0) cout_n = 1'b0;
  end

  // R6: stop mode never pulls the carry output low
  always_comb begin
    if (m == MODE_STOP) a_stop_cout_r6: assert (cout_n == 1'b1);
  end
endmodule

// File: rtl/hexcnt_stage.sv
module hexcnt_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode_sel,
  input  logic         cin_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         cout_n
);
  logic [W-1:0] nxt;

  hexcnt_ctrl #(.W(W)) u_ctrl (
    .mode_sel(mode_sel), .cin_n(cin_n), .cnt(q), .din(din),
    .nxt(nxt), .cout_n(cout_n)
  );

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  p_load_r1: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b00 |=> q == $past(din));
  p_up_r2: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && !cin_n) |=> q == $past(q) + 1'b1);
  p_down_r3: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10 && !cin_n) |=> q == $past(q) - 1'b1);
  p_inhibit_r4: assert property (@(posedge clk) disable iff (rst)
    (mode_sel[1] != mode_sel[0] && cin_n) |=> $stable(q));
  p_stop_r5: assert property (@(posedge clk) disable iff (rst)
    mode_sel == 2'b11 |=> $stable(q));
  p_reset_r8: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: rtl/hexcnt_chain.sv
module hexcnt_chain #(
  parameter int STAGES = 3,
  parameter int NIB    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            mode_sel,
  input  logic                  cin_n,
  input  logic [STAGES*NIB-1:0] load_val,
  output logic [STAGES*NIB-1:0] count,
  output logic                  cout_n
);
  localparam int TW = STAGES * NIB;
  logic [STAGES:0] carry_n;
  assign carry_n[0] = cin_n;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    hexcnt_stage #(.W(NIB)) u_stage (
      .clk(clk), .rst(rst), .mode_sel(mode_sel),
      .cin_n(carry_n[k]),
      .din(load_val[k*NIB +: NIB]),
      .q(count[k*NIB +: NIB]),
      .cout_n(carry_n[k+1])
    );
  end

  assign cout_n = carry_n[STAGES];

  p_chain_up_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b01 && !cin_n) |=> count == TW'($past(count) + 1'b1));
  p_chain_down_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b10 && !cin_n) |=> count == TW'($past(count) - 1'b1));
endmodule

// File: tb/hexcnt_chain_tb.sv
module hexcnt_chain_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 3;
  localparam int TW = STAGES * 4;

  logic clk = 0, rst = 1, cin_n = 1;
  logic [1:0] mode_sel = 2'b11;
  logic [TW-1:0] load_val = '0;
  logic [TW-1:0] count;
  logic cout_n;
  int checks = 0, errors = 0;
  logic [TW-1:0] model = '0;

  hexcnt_chain #(.STAGES(STAGES)) u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .cin_n(cin_n),
    .load_val(load_val), .count(count), .cout_n(cout_n));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [TW-1:0] f_next(logic [TW-1:0] c, logic [1:0] m,
                                          logic ci, logic [TW-1:0] d);
    case (m)
      2'b00: return d;
      2'b01: return ci ? c : c + 1'b1;
      2'b10: return ci ? c : c - 1'b1;
      default: return c;
    endcase
  endfunction

  function automatic logic f_cout(logic [TW-1:0] c, logic [1:0] m, logic ci);
    if (m == 2'b00) return 1'b0;
    if (!ci && m == 2'b01 && c == {TW{1'b1}}) return 1'b0;
    if (!ci && m == 2'b10 && c == '0) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // apply inputs after an edge, check cout_n before next edge, then step
  task automatic step(string req, logic [1:0] m, logic ci, logic [TW-1:0] d);
    mode_sel = m; cin_n = ci; load_val = d;
    #1;
    check(req, TW'(cout_n), TW'(f_cout(model, m, ci)));
    model = f_next(model, m, ci, d);
    @(posedge clk); #1;
    check(req, count, model);
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #1; @(posedge clk); #1;
    check("R8 reset", count, '0);
    rst = 0;
    // R1 load 12 up to full-scale top nibble corner
    step("R1 load", 2'b00, 1'b1, 12'h00C);
    step("R2 up", 2'b01, 1'b0, '0);
    step("R2 up", 2'b01, 1'b0, '0);
    check("R6 cout high below terminal", TW'(cout_n), TW'(1));
    step("R2 up", 2'b01, 1'b0, '0);
    // R4 inhibit at 15: carry out held high
    step("R4 inhibit up", 2'b01, 1'b1, '0);
    step("R7 carry into nibble1", 2'b01, 1'b0, '0);
    check("R7 chained value", count, 12'h010);
    // R3 load 3 down to wrap
    step("R1 load", 2'b00, 1'b0, 12'h003);
    for (int i = 0; i < 4; i++) step("R3 down", 2'b10, 1'b0, '0);
    check("R7 full wrap down", count, 12'hFFF);
    step("R5 stop", 2'b11, 1'b0, '0);
    step("R4 inhibit down", 2'b10, 1'b1, '0);
    // full-range up wrap with terminal carry out
    step("R1 load", 2'b00, 1'b0, 12'hFFE);
    step("R7 up", 2'b01, 1'b0, '0);
    step("R7 wrap up", 2'b01, 1'b0, '0);
    check("R7 wrapped to zero", count, '0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] m = 2'($urandom);
      logic ci = ($urandom % 4) == 0;
      logic [TW-1:0] d = TW'($urandom);
      if (m == 2'b00 && ($urandom % 3) != 0) m = 2'b01;
      step("R6 random", m, ci, d);
    end
    rst = 1; @(posedge clk); #1; rst = 0; model = '0;
    check("R8 reset again", count, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule